// File: doc/BRIEF.md
# Configurable GPIO Port with Latched Pin Interrupts

An eight-pin general-purpose I/O port in which each pin independently takes one of several behaviours: a driven output, a plain input, or one of three interrupt-source flavours (both-edge, chosen-edge and level-sensitive). A pin's behaviour comes from its bits in four port-wide registers: a value register, a direction register and two function-select registers. In the interrupt behaviours the value-register bit is not an output value. It selects the active level or the trigger edge.

Pin inputs are resynchronised before use. Edge events are held in a per-pin sticky flag until software writes a 1 to that pin's bit in a separate clear register. Level requests are never held: they follow the pin. The block presents a per-pin request vector and a single combined request line for an external interrupt controller.

Top module: `gpio_irq_port`

## Requirements
- R1: After reset the direction register reads 8'hFF, the other configuration registers and the sticky flags read 0, no output enable is active and no request is raised. Register offsets are: 0 value, 1 direction, 2 function-1, 3 function-2, 4 sticky-flag clear (reads back the sticky flags), 5 synchronised pin levels (read-only).
- R2: With function-2=0 and direction=0 a pin is an output: its output enable is 1 and its output carries its value bit. In every other configuration the output enable is 0.
- R3: With function-2=1, function-1=1 and direction=0 (both-edge mode) a rising or falling synchronised pin change sets the pin's sticky flag. The flag stays set after the pin returns to its earlier level.
- R4: With function-2=1, function-1=1 and direction=1 (chosen-edge mode) only one edge sets the flag: rising when the value bit was 1 on entry to the mode, falling when it was 0.
- R5: While a pin stays in chosen-edge mode, rewriting its value bit does not change the trigger edge. The new edge takes effect only after the pin leaves the mode and enters it again.
- R6: Writing the clear register clears the sticky flag of every pin whose written bit is 1. Bits written as 0 leave their flags unchanged.
- R7: When a qualifying edge and a clear of the same pin fall in the same cycle, the flag stays set.
- R8: With function-2=1, function-1=0 and direction=0 (level mode) the request equals the synchronised pin when the value bit is 1 and its inverse when the value bit is 0. It is not held after the level goes away.
- R9: Pins in output, input or other non-interrupt configurations never raise a request. Leaving an edge mode discards the pin's sticky flag.
- R10: The port request is the OR of the per-pin request vector.
- R11: Pin changes are seen through a two-stage synchroniser. Offset 5 returns the synchronised pin levels, and the configuration registers read back what was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| pin_in | input | 8 | Asynchronous pin levels |
| pin_out | output | 8 | Pin output values |
| pin_oe | output | 8 | Pin output enables |
| irq_vec | output | 8 | Per-pin interrupt requests |
| irq | output | 1 | Combined port request |

## Verification
Every pin configuration is swept with both value-bit settings. For each one the pins are driven through the same sequence: all low, the mixed pattern 8'hA5, back to low, then all high. Because some bits move and others stay still, the sequence separates rising-edge, falling-edge, both-edge and level behaviour from one another and from the quiet modes, bit by bit. Partial clear masks show that 0 bits are ignored. Rewriting the value bit while a pin stays in chosen-edge mode, followed by leaving and re-entering that mode, shows that the trigger edge is fixed on entry. A clear placed in the cycle of an edge shows that the edge takes priority.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  typedef enum logic [2:0] {
    PM_OUT    = 3'd0,
    PM_IN     = 3'd1,
    PM_DUAL   = 3'd2,
    PM_LEVEL  = 3'd3,
    PM_SINGLE = 3'd4
  } pin_mode_e;

  localparam logic [2:0] A_VALUE = 3'd0;
  localparam logic [2:0] A_DIR   = 3'd1;
  localparam logic [2:0] A_FN1   = 3'd2;
  localparam logic [2:0] A_FN2   = 3'd3;
  localparam logic [2:0] A_CLEAR = 3'd4;
  localparam logic [2:0] A_PINS  = 3'd5;

  // Pin behaviour from its function/direction bits.
  function automatic pin_mode_e decode_mode(input logic fn2, input logic fn1, input logic dir);
    if (!fn2 && !dir)            return PM_OUT;
    else if (fn2 && fn1 && !dir) return PM_DUAL;
    else if (fn2 && fn1 && dir)  return PM_SINGLE;
    else if (fn2 && !fn1 && !dir) return PM_LEVEL;
    else                          return PM_IN;
  endfunction

  function automatic logic level_active(input logic lvl, input logic polarity);
    return lvl == polarity;
  endfunction

  function automatic logic edge_hit(input logic now, input logic prev,
                                    input logic both, input logic rising);
    logic r, f;
    r = now & ~prev;
    f = ~now & prev;
    if (both) return r | f;
    return rising ? r : f;
  endfunction

endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q_now,
  output logic q_prev
);
  localparam int N = (STAGES < 2) ? 2 : STAGES;

  logic [N-1:0] chain;
  logic         prev_q;

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[g] <= 1'b0;
          else        chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= chain[N-1];
  end

  assign q_now  = chain[N-1];
  assign q_prev = prev_q;
endmodule

// File: rtl/gpio_pin_ctrl.sv
module gpio_pin_ctrl
  import gpio_irq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic val_bit,
  input  logic dir_bit,
  input  logic fn1_bit,
  input  logic fn2_bit,
  input  logic s_now,
  input  logic s_prev,
  input  logic clr_bit,
  output logic req,
  output logic flag_q,
  output logic edge_evt,
  output logic sel_q,
  output logic is_edge,
  output logic is_single,
  output logic is_irq,
  output logic is_out
);
  pin_mode_e mode;
  logic      was_single;
  logic      entering;
  logic      sel_eff;

  always_comb begin
    mode      = decode_mode(fn2_bit, fn1_bit, dir_bit);
    is_single = (mode == PM_SINGLE);
    is_edge   = (mode == PM_DUAL) || is_single;
    is_irq    = is_edge || (mode == PM_LEVEL);
    is_out    = (mode == PM_OUT);
    entering  = is_single && !was_single;
    sel_eff   = entering ? val_bit : sel_q;
    edge_evt  = is_edge && edge_hit(s_now, s_prev, mode == PM_DUAL, sel_eff);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      was_single <= 1'b0;
      sel_q      <= 1'b0;
      flag_q     <= 1'b0;
    end else begin
      was_single <= is_single;
      if (!is_single || entering) sel_q <= val_bit;
      if (!is_edge)      flag_q <= 1'b0;
      else if (edge_evt) flag_q <= 1'b1;
      else if (clr_bit)  flag_q <= 1'b0;
    end
  end

  always_comb begin
    unique case (mode)
      PM_LEVEL:          req = level_active(s_now, val_bit);
      PM_DUAL, PM_SINGLE: req = flag_q;
      default:           req = 1'b0;
    endcase
  end
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_irq_pkg::*;
#(
  parameter int W  = 8,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wdata,
  input  logic [W-1:0]  flags,
  input  logic [W-1:0]  levels,
  output logic [W-1:0]  rdata,
  output logic [W-1:0]  val_q,
  output logic [W-1:0]  dir_q,
  output logic [W-1:0]  fn1_q,
  output logic [W-1:0]  fn2_q,
  output logic [W-1:0]  clr_vec
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q <= '0;
      dir_q <= '1;
      fn1_q <= '0;
      fn2_q <= '0;
    end else if (wr) begin
      case (addr)
        AW'(A_VALUE): val_q <= wdata;
        AW'(A_DIR):   dir_q <= wdata;
        AW'(A_FN1):   fn1_q <= wdata;
        AW'(A_FN2):   fn2_q <= wdata;
        default: ;
      endcase
    end
  end

  assign clr_vec = (wr && addr == AW'(A_CLEAR)) ? wdata : '0;

  always_comb begin
    case (addr)
      AW'(A_VALUE): rdata = val_q;
      AW'(A_DIR):   rdata = dir_q;
      AW'(A_FN1):   rdata = fn1_q;
      AW'(A_FN2):   rdata = fn2_q;
      AW'(A_CLEAR): rdata = flags;
      AW'(A_PINS):  rdata = levels;
      default:      rdata = '0;
    endcase
  end
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
  import gpio_irq_pkg::*;
#(
  parameter int W           = 8,
  parameter int AW          = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [W-1:0]  bus_wdata,
  output logic [W-1:0]  bus_rdata,
  input  logic [W-1:0]  pin_in,
  output logic [W-1:0]  pin_out,
  output logic [W-1:0]  pin_oe,
  output logic [W-1:0]  irq_vec,
  output logic          irq
);
  logic [W-1:0] val_q, dir_q, fn1_q, fn2_q, clr_vec;
  logic [W-1:0] s_now, s_prev;
  logic [W-1:0] flag_q, edge_evt, sel_q, req;
  logic [W-1:0] edge_mask, single_mask, irq_mask, out_mask;

  gpio_regs #(.W(W), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .flags(flag_q), .levels(s_now), .rdata(bus_rdata),
    .val_q(val_q), .dir_q(dir_q), .fn1_q(fn1_q), .fn2_q(fn2_q), .clr_vec(clr_vec)
  );

  genvar i;
  generate
    for (i = 0; i < W; i++) begin : g_pin
      gpio_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(pin_in[i]), .q_now(s_now[i]), .q_prev(s_prev[i])
      );
      gpio_pin_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .val_bit(val_q[i]), .dir_bit(dir_q[i]), .fn1_bit(fn1_q[i]), .fn2_bit(fn2_q[i]),
        .s_now(s_now[i]), .s_prev(s_prev[i]), .clr_bit(clr_vec[i]),
        .req(req[i]), .flag_q(flag_q[i]), .edge_evt(edge_evt[i]), .sel_q(sel_q[i]),
        .is_edge(edge_mask[i]), .is_single(single_mask[i]),
        .is_irq(irq_mask[i]), .is_out(out_mask[i])
      );
    end
  endgenerate

  assign pin_out = val_q;
  assign pin_oe  = out_mask;
  assign irq_vec = req;
  assign irq     = |req;
endmodule

// File: rtl/gpio_irq_port_chk.sv
module gpio_irq_port_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] irq_vec,
  input logic         irq,
  input logic [W-1:0] flag_q,
  input logic [W-1:0] edge_evt,
  input logic [W-1:0] clr_vec,
  input logic [W-1:0] sel_q,
  input logic [W-1:0] edge_mask,
  input logic [W-1:0] single_mask,
  input logic [W-1:0] irq_mask
);
  assert_irq_or_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (irq_vec != '0));

  assert_quiet_modes_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_vec & ~irq_mask) == '0);

  assert_flag_dropped_R9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (flag_q & ~$past(edge_mask)) == '0);

  assert_flag_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (~flag_q & $past(flag_q & ~clr_vec & edge_mask)) == '0);

  assert_w1c_R6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (flag_q & $past(clr_vec & ~edge_evt)) == '0);

  assert_event_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (flag_q & $past(edge_evt)) == $past(edge_evt));

  assert_edge_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((sel_q ^ $past(sel_q)) & single_mask & $past(single_mask)) == '0);
endmodule

bind gpio_irq_port gpio_irq_port_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_vec(irq_vec), .irq(irq),
  .flag_q(flag_q), .edge_evt(edge_evt), .clr_vec(clr_vec), .sel_q(sel_q),
  .edge_mask(edge_mask), .single_mask(single_mask), .irq_mask(irq_mask)
);

// File: tb/gpio_irq_port_test.sv
module gpio_irq_port_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0;
  logic [2:0] bus_addr = 3'd0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata, pin_out, pin_oe, irq_vec;
  logic [7:0] pin_in = 8'h00;
  logic       irq;

  int errors = 0;
  int checks = 0;

  // bench-side model
  int         m_mode;   // 0 out,1 in,2 dual,3 level,4 single
  logic       m_val;
  logic       m_sel;
  logic [7:0] m_flag;
  logic [7:0] m_pins;

  gpio_irq_port uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq_vec(irq_vec), .irq(irq)
  );

  always #5 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  function automatic logic [7:0] exp_req();
    case (m_mode)
      2, 4:    return m_flag;
      3:       return m_val ? m_pins : ~m_pins;
      default: return 8'h00;
    endcase
  endfunction

  // Goes through plain input, then into the target configuration.
  task automatic set_mode(input int mode, input logic v);
    logic [7:0] f2, f1, dr;
    case (mode)
      0:       begin f2 = 8'h00; f1 = 8'h00; dr = 8'h00; end
      1:       begin f2 = 8'h00; f1 = 8'h00; dr = 8'hFF; end
      2:       begin f2 = 8'hFF; f1 = 8'hFF; dr = 8'h00; end
      3:       begin f2 = 8'hFF; f1 = 8'h00; dr = 8'h00; end
      default: begin f2 = 8'hFF; f1 = 8'hFF; dr = 8'hFF; end
    endcase
    wr_reg(3'd3, 8'h00); wr_reg(3'd2, 8'h00); wr_reg(3'd1, 8'hFF);
    wr_reg(3'd0, {8{v}}); wr_reg(3'd3, f2); wr_reg(3'd2, f1); wr_reg(3'd1, dr);
    m_mode = mode; m_val = v; m_sel = v; m_flag = 8'h00;
    wr_reg(3'd4, 8'hFF);
  endtask

  task automatic drive(input logic [7:0] p);
    logic [7:0] r, f;
    @(negedge clk);
    r = p & ~m_pins; f = ~p & m_pins;
    pin_in = p;
    if (m_mode == 2) m_flag |= (r | f);
    if (m_mode == 4) m_flag |= (m_sel ? r : f);
    m_pins = p;
    repeat (4) @(negedge clk);
  endtask

  task automatic observe(input string tag);
    logic [7:0] d;
    check({tag, " R3/R4/R8 irq_vec"}, irq_vec, exp_req());
    check({tag, " R10 irq"}, irq, exp_req() != 0);
    rd_reg(3'd4, d);
    check({tag, " R6 flags"}, d, (m_mode == 2 || m_mode == 4) ? m_flag : 8'h00);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] d;
    m_pins = 8'h00; m_flag = 8'h00; m_mode = 1; m_val = 0; m_sel = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    check("R1 irq", irq, 1'b0);
    check("R1 oe", pin_oe, 8'h00);
    rd_reg(3'd1, d); check("R1 dir", d, 8'hFF);
    rd_reg(3'd0, d); check("R1 value", d, 8'h00);
    rd_reg(3'd4, d); check("R1 flags", d, 8'h00);

    // Sweep every configuration with both value settings
    for (int mode = 0; mode < 5; mode++) begin
      for (int v = 0; v < 2; v++) begin
        set_mode(mode, v[0]);
        check("R2 oe", pin_oe, (mode == 0) ? 8'hFF : 8'h00);
        check("R2 out", pin_out, {8{v[0]}});
        rd_reg(3'd2, d);
        check("R11 fn1 readback", d, (mode == 2 || mode == 4) ? 8'hFF : 8'h00);
        observe("idle");
        drive(8'hA5); observe("rise");
        rd_reg(3'd5, d); check("R11 pin levels", d, 8'hA5);
        drive(8'h00); observe("fall");
        // R6: partial clear, zero bits untouched
        wr_reg(3'd4, 8'h0F); m_flag &= 8'hF0; observe("R6 partial clear");
        drive(8'hFF); observe("all high");
        wr_reg(3'd4, 8'hFF); m_flag = 8'h00; observe("R6 full clear");
        drive(8'h00); observe("back low");
        // R9: leaving an edge mode drops flags
        wr_reg(3'd3, 8'h00);
        m_mode = (mode == 4) ? 1 : 0; m_flag = 8'h00;
        check("R9 no request after leaving", irq_vec, 8'h00);
        m_mode = mode;
        wr_reg(3'd4, 8'hFF);
        m_pins = 8'h00; pin_in = 8'h00; repeat (4) @(negedge clk);
      end
    end

    // R5: edge fixed on entry to chosen-edge mode
    set_mode(4, 1'b1);
    wr_reg(3'd0, 8'h00);            // stays in mode, edge unchanged
    drive(8'h3C); observe("R5 rise still counts");
    wr_reg(3'd4, 8'hFF); m_flag = 8'h00;
    drive(8'h00); observe("R5 fall ignored");
    set_mode(4, 1'b0);              // re-entry with falling edge
    drive(8'hFF); observe("R5 rise ignored after re-entry");
    drive(8'h00); observe("R5 fall counts after re-entry");

    // R7: edge and clear in the same cycle
    set_mode(2, 1'b0);
    drive(8'h02);
    @(negedge clk); pin_in = 8'h03;
    @(posedge clk); @(posedge clk);
    @(negedge clk); bus_wr = 1'b1; bus_addr = 3'd4; bus_wdata = 8'h03;
    @(negedge clk); bus_wr = 1'b0;
    m_pins = 8'h03; m_flag = 8'h01;
    repeat (2) @(negedge clk);
    rd_reg(3'd4, d); check("R7 edge beats clear", d, 8'h01);
    check("R7 irq_vec", irq_vec, 8'h01);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule